// File: doc/BRIEF.md
# Byte-Coded Accumulator Processor Core

This block is a small multi-cycle processor built around one 8-bit accumulator. A six-state controller steers a datapath made of the accumulator, a carry flag, an 8-bit program counter and one synchronous memory port. Instructions are one or two bytes long. Each one takes between one and three clock cycles, depending on its opcode.

The memory port addresses 512 bytes with a 9-bit address. When bit 8 is clear, the address selects the 256-byte program store. When bit 8 is set, it selects the 256-byte data store. The sixteen general registers are the first sixteen bytes of the data store, so register r is found at address 0x100 + r. A read returns its data one cycle after the address is presented.

A set of 4-bit port numbers exchanges values with the outside world. The IO output side carries a value, the selected port number and a one-cycle strobe. It has no back-pressure: the consumer must take the value in the cycle the strobe is high. The IO input is sampled in that same cycle. The arithmetic unit and the shifter are separate blocks under the top.

Top module: `acc_cpu`

## Requirements
- R1: After reset the controller is in its fetch state, with accumulator, carry and program counter at zero. `halted`, `io_strobe` and `mem_wr_en` are low and `io_out` is zero. While reset is held, `mem_rd_addr` is 0, so the first opcode is read from program address 0.
- R2: An opcode with bit 7 clear (`0fff rrrr`) sets A to A f m[0x100+r] and takes two cycles. The function codes are:
  - f=000: add
  - f=001: subtract
  - f=010: add with carry
  - f=011: subtract with borrow
  - f=100: AND
  - f=101: OR
  - f=110: XOR
  - f=111: load the operand
- R3: Opcode `1000 rrrr` writes A to address 0x100+r and takes one cycle.
- R4: Opcode `1001 rrrr` writes the address of the next opcode (PC+1) to 0x100+r, then continues at the address held in A. It takes one cycle.
- R5: Opcode `1010 rrrr` sets A to m[0x100+m[0x100+r]] in three cycles. Opcode `1011 rrrr` writes A to 0x100+m[0x100+r] in two cycles.
- R6: Opcode `1100 -fff` is followed by an immediate byte n. It sets A to A f n, using the function codes of R2, and takes two cycles.
- R7: Opcode `1101 --cc` is followed by a target byte and takes two cycles. The branch condition depends on cc:
  - cc=00: always jumps
  - cc=10: jumps when A is zero
  - cc=11: jumps when A is nonzero
  - cc=01: never jumps
  
  When the branch is not taken, execution continues after the target byte.
- R8: Opcode `1110 --ss` shifts A in one cycle. The shift depends on ss:
  - ss=00: shift left, filling with zero
  - ss=01: shift right, filling with zero
  - ss=10: rotate left
  - ss=11: rotate right
  
  Shifts and the logic functions leave the carry unchanged.
- R9: Opcode `1111 pppp`, with pppp other than 1111, does three things in one cycle. It presents A on `io_out` and pppp on `io_sel`. It pulses `io_strobe` high for exactly one cycle. It loads A from `io_in`.
- R10: Opcode 0xFF halts the core. `halted` then stays high, the program counter and read address hold, and no further memory writes occur.
- R11: The run time of a program from reset release until `halted` rises equals the sum of the per-opcode cycle counts given in R2–R10, with the halt opcode counting as one cycle.
- R12: Every memory write has address bit 8 set, so writes always go to the data store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rd_addr | output | 9 | Read address; bit 8 selects the data store |
| mem_rd_data | input | 8 | Read data, valid one cycle after the address |
| mem_wr_en | output | 1 | Write enable for the data store |
| mem_wr_addr | output | 9 | Write address |
| mem_wr_data | output | 8 | Write data |
| io_in | input | 8 | Value sampled by an IO opcode |
| io_out | output | 8 | Last value written by an IO opcode |
| io_sel | output | 4 | Port number of the last IO opcode |
| io_strobe | output | 1 | High for one cycle after each IO opcode |
| halted | output | 1 | High once the halt opcode has executed |

## Verification
Each result lands at a known cycle:
- An accumulator change is complete at the clock edge that ends the opcode's last cycle.
- A store is written at the edge ending the cycle that drives the write.
- `io_out`, `io_sel` and `io_strobe` change at the edge ending the IO opcode's single cycle.
- `halted` rises at the edge ending the halt cycle.

The bench drives inputs and samples every output on the falling edge, half a cycle after the register that produces it. An instruction-level reference model replays each program and predicts three things: the data store image, the IO trace and the exact number of edges until `halted`. Counting edges against that prediction checks every opcode's latency.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int DW     = 8;
  localparam int AW     = DW + 1;
  localparam int RSEL_W = 4;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_EXEC   = 3'd1,
    ST_STIND  = 3'd2,
    ST_LDIND1 = 3'd3,
    ST_LDIND2 = 3'd4,
    ST_EXIT   = 3'd5
  } state_t;

  typedef enum logic [2:0] {
    FN_ADD = 3'd0,
    FN_SUB = 3'd1,
    FN_ADC = 3'd2,
    FN_SBB = 3'd3,
    FN_AND = 3'd4,
    FN_OR  = 3'd5,
    FN_XOR = 3'd6,
    FN_LD  = 3'd7
  } alu_fn_t;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RIGHT = 2'd1,
    SH_ROL   = 2'd2,
    SH_ROR   = 2'd3
  } shift_fn_t;
endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_fn_t        fn,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cin,
  output logic [W-1:0]   res,
  output logic           cout
);
  localparam logic [W:0] ONE = {{W{1'b0}}, 1'b1};

  logic [W:0] wide;
  logic [W:0] cext;

  assign cext = cin ? ONE : '0;

  always_comb begin
    wide = '0;
    res  = a;
    cout = cin;
    unique case (fn)
      FN_ADD: begin wide = {1'b0, a} + {1'b0, b};        res = wide[W-1:0]; cout = wide[W]; end
      FN_SUB: begin wide = {1'b0, a} - {1'b0, b};        res = wide[W-1:0]; cout = wide[W]; end
      FN_ADC: begin wide = {1'b0, a} + {1'b0, b} + cext; res = wide[W-1:0]; cout = wide[W]; end
      FN_SBB: begin wide = {1'b0, a} - {1'b0, b} - cext; res = wide[W-1:0]; cout = wide[W]; end
      FN_AND: res = a & b;
      FN_OR:  res = a | b;
      FN_XOR: res = a ^ b;
      FN_LD:  res = b;
      default: res = a;
    endcase
  end
endmodule

// File: rtl/acc_shifter.sv
module acc_shifter
  import acc_pkg::*;
#(
  parameter int W = 8
) (
  input  shift_fn_t    fn,
  input  logic [W-1:0] a,
  output logic [W-1:0] res
);
  logic [W-1:0] left_v;
  logic [W-1:0] right_v;
  logic         lsb_in;
  logic         msb_in;

  assign lsb_in = (fn == SH_ROL) ? a[W-1] : 1'b0;
  assign msb_in = (fn == SH_ROR) ? a[0]   : 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lo
      assign left_v[i] = lsb_in;
    end else begin : g_lo_n
      assign left_v[i] = a[i-1];
    end
    if (i == W - 1) begin : g_hi
      assign right_v[i] = msb_in;
    end else begin : g_hi_n
      assign right_v[i] = a[i+1];
    end
  end

  assign res = fn[0] ? right_v : left_v;
endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     rd_data,
  input  logic [DW-1:0]     io_in,
  input  logic [DW-1:0]     alu_res,
  input  logic              alu_cout,
  input  logic [DW-1:0]     sh_res,
  output alu_fn_t           alu_fn,
  output logic [DW-1:0]     acc,
  output logic              carry,
  output logic [AW-1:0]     rd_addr,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     io_out,
  output logic [RSEL_W-1:0] io_sel,
  output logic              io_strobe,
  output logic              halted
);
  localparam logic [DW-1:0] ALL_ONES = {DW{1'b1}};
  localparam int            PADW     = DW - RSEL_W;

  state_t          state_q, state_d;
  logic [DW-1:0]   acc_q, acc_nxt, pc_q, pc_nxt;
  logic            acc_we, pc_we, carry_q, carry_we;
  alu_fn_t         fn_q, fn_d;
  logic            br_q, br_d;
  logic [1:0]      cond_q, cond_d;
  logic            io_we, io_stb_q;
  logic [DW-1:0]   io_out_q;
  logic [RSEL_W-1:0] io_sel_q;
  logic            use_ram;
  logic [DW-1:0]   ram_lo;
  logic            wr_en_c;
  logic [AW-1:0]   wr_addr_c;
  logic [DW-1:0]   wr_data_c;
  logic            taken;
  logic [DW-1:0]   reg_lo;
  logic [AW-1:0]   rd_addr_c;

  assign reg_lo = {{PADW{1'b0}}, rd_data[RSEL_W-1:0]};
  assign taken  = (cond_q == 2'b00) ||
                  ((cond_q == 2'b10) && (acc_q == '0)) ||
                  ((cond_q == 2'b11) && (acc_q != '0));

  always_comb begin
    state_d   = state_q;
    acc_nxt   = acc_q;
    acc_we    = 1'b0;
    carry_we  = 1'b0;
    pc_nxt    = pc_q + 1'b1;
    pc_we     = 1'b0;
    fn_d      = fn_q;
    br_d      = br_q;
    cond_d    = cond_q;
    io_we     = 1'b0;
    use_ram   = 1'b0;
    ram_lo    = reg_lo;
    wr_en_c   = 1'b0;
    wr_addr_c = {1'b1, reg_lo};
    wr_data_c = acc_q;
    unique case (state_q)
      ST_FETCH: begin
        if (!rd_data[DW-1]) begin
          fn_d    = alu_fn_t'(rd_data[6:4]);
          br_d    = 1'b0;
          use_ram = 1'b1;
          state_d = ST_EXEC;
        end else begin
          unique case (rd_data[6:4])
            3'b000: begin wr_en_c = 1'b1; pc_we = 1'b1; end
            3'b001: begin
              wr_en_c   = 1'b1;
              wr_data_c = pc_q + 1'b1;
              pc_nxt    = acc_q;
              pc_we     = 1'b1;
            end
            3'b010: begin use_ram = 1'b1; state_d = ST_LDIND1; end
            3'b011: begin use_ram = 1'b1; state_d = ST_STIND; end
            3'b100: begin
              fn_d = alu_fn_t'(rd_data[2:0]); br_d = 1'b0; pc_we = 1'b1; state_d = ST_EXEC;
            end
            3'b101: begin
              cond_d = rd_data[1:0]; br_d = 1'b1; pc_we = 1'b1; state_d = ST_EXEC;
            end
            3'b110: begin acc_nxt = sh_res; acc_we = 1'b1; pc_we = 1'b1; end
            default: begin
              if (rd_data == ALL_ONES) begin
                state_d = ST_EXIT;
              end else begin
                io_we   = 1'b1;
                acc_nxt = io_in;
                acc_we  = 1'b1;
                pc_we   = 1'b1;
              end
            end
          endcase
        end
      end
      ST_EXEC: begin
        pc_we   = 1'b1;
        state_d = ST_FETCH;
        if (br_q) begin
          if (taken) pc_nxt = rd_data;
        end else begin
          acc_nxt  = alu_res;
          acc_we   = 1'b1;
          carry_we = 1'b1;
        end
      end
      ST_STIND: begin
        wr_en_c   = 1'b1;
        wr_addr_c = {1'b1, rd_data};
        pc_we     = 1'b1;
        state_d   = ST_FETCH;
      end
      ST_LDIND1: begin
        use_ram = 1'b1;
        ram_lo  = rd_data;
        state_d = ST_LDIND2;
      end
      ST_LDIND2: begin
        acc_nxt = rd_data;
        acc_we  = 1'b1;
        pc_we   = 1'b1;
        state_d = ST_FETCH;
      end
      default: state_d = ST_EXIT;
    endcase
    rd_addr_c = use_ram ? {1'b1, ram_lo} : {1'b0, (pc_we ? pc_nxt : pc_q)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_FETCH;
      acc_q    <= '0;
      carry_q  <= 1'b0;
      pc_q     <= '0;
      fn_q     <= FN_ADD;
      br_q     <= 1'b0;
      cond_q   <= 2'b00;
      io_out_q <= '0;
      io_sel_q <= '0;
      io_stb_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      fn_q     <= fn_d;
      br_q     <= br_d;
      cond_q   <= cond_d;
      io_stb_q <= io_we;
      if (acc_we)   acc_q   <= acc_nxt;
      if (carry_we) carry_q <= alu_cout;
      if (pc_we)    pc_q    <= pc_nxt;
      if (io_we) begin
        io_out_q <= acc_q;
        io_sel_q <= rd_data[RSEL_W-1:0];
      end
    end
  end

  assign alu_fn    = fn_q;
  assign acc       = acc_q;
  assign carry     = carry_q;
  assign rd_addr   = rst_n ? rd_addr_c : '0;
  assign wr_en     = wr_en_c;
  assign wr_addr   = wr_addr_c;
  assign wr_data   = wr_data_c;
  assign io_out    = io_out_q;
  assign io_sel    = io_sel_q;
  assign io_strobe = io_stb_q;
  assign halted    = (state_q == ST_EXIT);

  AST_EXIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EXIT) |=> (state_q == ST_EXIT) && $stable(pc_q)); // R10
  AST_EXIT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EXIT) |-> !wr_en); // R10
  AST_LDIND_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LDIND1) |=> (state_q == ST_LDIND2)); // R5
  AST_STORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH && rd_data[7:5] == 3'b100) |=> (state_q == ST_FETCH)); // R3
  AST_SHIFT_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH && rd_data[7:4] == 4'hE) |=> (pc_q == $past(pc_q) + 8'd1)); // R8
  AST_STROBE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_strobe) |-> $past(state_q == ST_FETCH && rd_data[7:4] == 4'hF)); // R9
  AST_WRITE_IN_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_addr[AW-1]); // R12
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  output logic [8:0] mem_rd_addr,
  input  logic [7:0] mem_rd_data,
  output logic       mem_wr_en,
  output logic [8:0] mem_wr_addr,
  output logic [7:0] mem_wr_data,
  input  logic [7:0] io_in,
  output logic [7:0] io_out,
  output logic [3:0] io_sel,
  output logic       io_strobe,
  output logic       halted
);
  alu_fn_t       alu_fn;
  logic [DW-1:0] acc, alu_res, sh_res;
  logic          carry, alu_cout;

  acc_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_data   (mem_rd_data),
    .io_in     (io_in),
    .alu_res   (alu_res),
    .alu_cout  (alu_cout),
    .sh_res    (sh_res),
    .alu_fn    (alu_fn),
    .acc       (acc),
    .carry     (carry),
    .rd_addr   (mem_rd_addr),
    .wr_en     (mem_wr_en),
    .wr_addr   (mem_wr_addr),
    .wr_data   (mem_wr_data),
    .io_out    (io_out),
    .io_sel    (io_sel),
    .io_strobe (io_strobe),
    .halted    (halted)
  );

  acc_alu #(.W(DW)) u_alu (
    .fn   (alu_fn),
    .a    (acc),
    .b    (mem_rd_data),
    .cin  (carry),
    .res  (alu_res),
    .cout (alu_cout)
  );

  acc_shifter #(.W(DW)) u_shift (
    .fn  (shift_fn_t'(mem_rd_data[1:0])),
    .a   (acc),
    .res (sh_res)
  );

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R10
endmodule

// File: tb/acc_cpu_test.sv
module acc_cpu_test;
  localparam int NP    = 6;
  localparam int PLEN  = 24;
  localparam logic [7:0] IO_IN_VAL = 8'h5C;

  // program table and hand-derived final io_out value
  localparam logic [7:0] PROG [NP][PLEN] = '{
    '{8'hC7,8'h12,8'h81,8'hC7,8'h34,8'h82,8'hC7,8'h00,8'h01,8'h02,8'hF0,8'hFF,
      8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00},
    '{8'hC7,8'h05,8'h83,8'hC7,8'h00,8'h84,8'h74,8'hC0,8'h03,8'h84,8'h73,8'hC1,
      8'h01,8'h83,8'hD3,8'h06,8'h74,8'hF1,8'hFF,8'h00,8'h00,8'h00,8'h00,8'h00},
    '{8'hC7,8'h20,8'h80,8'hC7,8'hAB,8'hB0,8'hC7,8'h00,8'hA0,8'hC0,8'h60,8'hC2,
      8'h00,8'hF2,8'hFF,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00},
    '{8'hC7,8'h81,8'hE2,8'hE0,8'hE3,8'hE1,8'hC5,8'hF0,8'hC6,8'h0F,8'hC4,8'h3C,
      8'hC1,8'h40,8'hC3,8'h00,8'hF3,8'hFF,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00},
    '{8'hC7,8'h08,8'h95,8'hC7,8'h77,8'hF4,8'hFF,8'h00,8'h75,8'hC1,8'h03,8'hD2,
      8'h0E,8'hFF,8'hC7,8'h5A,8'hF4,8'hFF,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00},
    '{8'hC7,8'h00,8'hD1,8'h07,8'hC7,8'h11,8'hF0,8'hFF,8'h00,8'h00,8'h00,8'h00,
      8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00}
  };
  localparam logic [7:0] EXP_IO [NP] = '{8'h46, 8'h0F, 8'h0C, 8'hFB, 8'h5A, 8'h11};
  localparam string TAGS [NP] = '{"R2 R3 R6", "R7 R2 R3", "R5 R6 R2",
                                  "R8 R6", "R4 R7", "R7 R9"};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] mem_rd_addr, mem_wr_addr;
  logic [7:0] mem_rd_data, mem_wr_data, io_out;
  logic       mem_wr_en, io_strobe, halted;
  logic [3:0] io_sel;
  logic [7:0] io_in = IO_IN_VAL;

  logic [7:0] rom [256];
  logic [7:0] ram [256];
  logic [7:0] m_ram [256];
  logic       ram_clr = 1'b1;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int strobes = 0, bad_wr = 0;
  int m_cycles, m_io_cnt;
  logic [7:0] m_last_io;
  logic [3:0] m_last_sel;

  always #5 clk = ~clk;

  acc_cpu uut (
    .clk(clk), .rst_n(rst_n),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .io_in(io_in), .io_out(io_out), .io_sel(io_sel),
    .io_strobe(io_strobe), .halted(halted)
  );

  always @(posedge clk) begin
    mem_rd_data <= mem_rd_addr[8] ? ram[mem_rd_addr[7:0]] : rom[mem_rd_addr[7:0]];
    if (ram_clr) begin
      for (int i = 0; i < 256; i++) ram[i] <= 8'h00;
    end else if (mem_wr_en) begin
      ram[mem_wr_addr[7:0]] <= mem_wr_data;
    end
  end

  always @(negedge clk) begin
    if (rst_n && io_strobe) strobes <= strobes + 1;
    if (rst_n && mem_wr_en && !mem_wr_addr[8]) bad_wr <= bad_wr + 1;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] model_alu(input logic [2:0] f, input logic [7:0] a,
                                           input logic [7:0] b, input logic c);
    int s;
    case (f)
      3'd0: begin s = int'(a) + int'(b);         return {s > 255, 8'(s)}; end
      3'd1: begin s = int'(a) - int'(b);         return {s < 0, 8'(s)}; end
      3'd2: begin s = int'(a) + int'(b) + int'(c); return {s > 255, 8'(s)}; end
      3'd3: begin s = int'(a) - int'(b) - int'(c); return {s < 0, 8'(s)}; end
      3'd4: return {c, a & b};
      3'd5: return {c, a | b};
      3'd6: return {c, a ^ b};
      default: return {c, b};
    endcase
  endfunction

  task automatic run_model();
    logic [7:0] a = 0, pc = 0, op, nb;
    logic       c = 0, tk;
    logic [8:0] r;
    bit done = 0;
    int guard = 0;
    for (int i = 0; i < 256; i++) m_ram[i] = 8'h00;
    m_cycles = 0; m_io_cnt = 0; m_last_io = 0; m_last_sel = 0;
    while (!done && guard < 4000) begin
      guard++;
      op = rom[pc];
      nb = rom[8'(pc + 8'd1)];
      if (!op[7]) begin
        r = model_alu(op[6:4], a, m_ram[op[3:0]], c); c = r[8]; a = r[7:0];
        pc = pc + 1; m_cycles += 2;
      end else begin
        case (op[6:4])
          3'd0: begin m_ram[op[3:0]] = a; pc = pc + 1; m_cycles += 1; end
          3'd1: begin m_ram[op[3:0]] = pc + 8'd1; pc = a; m_cycles += 1; end
          3'd2: begin a = m_ram[m_ram[op[3:0]]]; pc = pc + 1; m_cycles += 3; end
          3'd3: begin m_ram[m_ram[op[3:0]]] = a; pc = pc + 1; m_cycles += 2; end
          3'd4: begin
            r = model_alu(op[2:0], a, nb, c); c = r[8]; a = r[7:0];
            pc = pc + 2; m_cycles += 2;
          end
          3'd5: begin
            tk = (op[1:0] == 2'b00) || (op[1:0] == 2'b10 && a == 0) || (op[1:0] == 2'b11 && a != 0);
            pc = tk ? nb : 8'(pc + 8'd2); m_cycles += 2;
          end
          3'd6: begin
            case (op[1:0])
              2'd0: a = a << 1;
              2'd1: a = a >> 1;
              2'd2: a = {a[6:0], a[7]};
              default: a = {a[0], a[7:1]};
            endcase
            pc = pc + 1; m_cycles += 1;
          end
          default: begin
            m_cycles += 1;
            if (op == 8'hFF) done = 1;
            else begin
              m_last_io = a; m_last_sel = op[3:0]; m_io_cnt++;
              a = IO_IN_VAL; pc = pc + 1;
            end
          end
        endcase
      end
    end
  endtask

  task automatic load_prog(input int k);
    for (int i = 0; i < 256; i++) rom[i] = (i < PLEN) ? PROG[k][i] : 8'h00;
  endtask

  task automatic reset_core();
    @(negedge clk);
    rst_n = 1'b0; ram_clr = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    ram_clr = 1'b0; strobes = 0; bad_wr = 0;
    rst_n = 1'b1;
  endtask

  task automatic run_to_halt(output int n);
    n = 0;
    while (!halted && n < 5000) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    int first_bad;
    logic [8:0] hold_addr;
    // reset state checks, R1
    load_prog(0);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", "rd_addr in reset", 32'(mem_rd_addr), 0);
    chk("R1", "halted in reset", 32'(halted), 0);
    chk("R1", "strobe/write in reset", 32'({io_strobe, mem_wr_en}), 0);
    chk("R1", "io_out in reset", 32'(io_out), 0);

    // table of programs
    for (int k = 0; k < NP; k++) begin
      load_prog(k);
      run_model();
      reset_core();
      run_to_halt(n);
      chk(TAGS[k], $sformatf("prog %0d io_out hand", k), 32'(io_out), 32'(EXP_IO[k]));
      chk(TAGS[k], $sformatf("prog %0d io_out model", k), 32'(io_out), 32'(m_last_io));
      chk("R9", $sformatf("prog %0d io_sel", k), 32'(io_sel), 32'(m_last_sel));
      chk("R9", $sformatf("prog %0d strobe count", k), 32'(strobes), 32'(m_io_cnt));
      chk("R11", $sformatf("prog %0d cycles", k), 32'(n), 32'(m_cycles));
      first_bad = -1;
      for (int i = 255; i >= 0; i--) if (ram[i] !== m_ram[i]) first_bad = i;
      if (first_bad < 0) chk("R3 R4 R5", $sformatf("prog %0d data image", k), 0, 0);
      else chk("R3 R4 R5", $sformatf("prog %0d data[%0h]", k, first_bad),
               32'(ram[first_bad]), 32'(m_ram[first_bad]));
      chk("R12", $sformatf("prog %0d writes outside data store", k), 32'(bad_wr), 0);
    end

    // halt holds, R10
    hold_addr = mem_rd_addr;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!halted || mem_wr_en || mem_rd_addr !== hold_addr) n++;
    end
    chk("R10", "halt hold violations", 32'(n), 0);
    chk("R10", "halted after wait", 32'(halted), 1);

    // reset in the middle of a run, R1
    load_prog(1);
    reset_core();
    repeat (9) @(negedge clk);
    load_prog(0);
    reset_core();
    chk("R1", "io_out after mid-run reset", 32'(io_out), 0);
    run_to_halt(n);
    chk("R1", "sum after mid-run reset", 32'(io_out), 32'h46);
    chk("R11", "sum program cycles", 32'(n), 14);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL R11 watchdog: actual %0d expected below 150000 cycles", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end
endmodule